// File: doc/BRIEF.md
# GPIO-Sourced Interrupt Channel Mapper

The mapper turns a wide bank of GPIO interrupt lines into 32 interrupt channels. Each channel has a packed 8-bit source field. The field holds an enable flag and the index of the GPIO line that feeds the channel. A 2-bit sense code per channel makes the channel react to a rising edge, a falling edge, a high level or a low level on that line. A detected event latches into a per-channel status bit. The status bit drives an active-high level request toward a parent interrupt controller.

Software configures the block through a simple synchronous write port and reads it through a combinational read port. It acknowledges a channel by writing the status register back with that channel's bit at zero. Each channel keeps a one-cycle history of its source. It also keeps a one-cycle "armed" flag. Together these stop a change of enable or of source index from counting as an edge.

Top module: `gim_mapper`

## Requirements
- R1: After reset every register reads zero and `irq_req` is zero.
- R2: Channel c has its source field in the register at address 0x30 + 4*(c/4), at bits [8*(c%4)+7 : 8*(c%4)]. Bit 7 of the field is the enable and bits 6:0 are the GPIO line index. The written value reads back unchanged.
- R3: With sense code 0, the channel sets its status bit once for each 0-to-1 transition of its source. A source that stays high does not set it again.
- R4: With sense code 1, the channel sets its status bit on each 1-to-0 transition of its source.
- R5: With sense code 2, the channel sets its status bit in every cycle in which its source is high.
- R6: With sense code 3, the channel sets its status bit in every cycle in which its source is low.
- R7: The sense code of channels 0..15 is in the register at 0x24, and the sense code of channels 16..31 is in the register at 0x28. Channel c uses bits [2i+1:2i] of its register, where i = c mod 16.
- R8: A channel whose enable bit is 0 never sets its status bit, whatever its source does.
- R9: Enabling a channel, or changing its source index, while the new source is already at its active value does not produce an edge event.
- R10: A write to the status register at 0x20 clears each status bit that the write data holds at 0. Writing 1 to a status bit has no effect.
- R11: When a status clear and a new event for the same channel fall in the same cycle, the bit stays set.
- R12: `irq_req[c]` is high exactly when status bit c is set, as read back at 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Register read data, combinational |
| gpio_lines | input | 128 | GPIO interrupt source bank |
| irq_req | output | 32 | Active-high level requests to the parent controller |

## Verification
The status latch can receive a software clear and a fresh event for the same channel in one cycle. The bench provokes this by writing zero to the status register while a level-high channel's source is held high. The bench judges the case by requiring the bit to still read set after the write. The second overlap is a source-field write that coincides with a source already at its active value. The bench switches a channel's line index, with the channel enabled, onto a line that is already high. It then checks that no request appears.

// File: rtl/gim_pkg.sv
package gim_pkg;

    localparam int CH_COUNT     = 32;
    localparam int LINE_COUNT   = 128;
    localparam int IDX_W        = 7;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 8;
    localparam int CH_PER_SEL   = 4;
    localparam int CH_PER_SNS   = 16;

    localparam logic [ADDR_W-1:0] ADDR_STATUS   = 8'h20;
    localparam logic [ADDR_W-1:0] ADDR_SNS_BASE = 8'h24;
    localparam logic [ADDR_W-1:0] ADDR_SEL_BASE = 8'h30;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
    } src_sel_t;

    typedef enum logic [1:0] {
        SNS_RISE = 2'd0,
        SNS_FALL = 2'd1,
        SNS_HIGH = 2'd2,
        SNS_LOW  = 2'd3
    } sense_e;

    function automatic logic [ADDR_W-1:0] sel_addr(input int k);
        return ADDR_SEL_BASE + ADDR_W'(4 * k);
    endfunction

    function automatic logic [ADDR_W-1:0] sns_addr(input int j);
        return ADDR_SNS_BASE + ADDR_W'(4 * j);
    endfunction

endpackage

// File: rtl/gim_regs.sv
module gim_regs
    import gim_pkg::*;
#(
    parameter int N_CH = CH_COUNT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [N_CH-1:0]       evt_vec,
    output src_sel_t              sel_cfg [N_CH],
    output sense_e                sns_cfg [N_CH],
    output logic [N_CH-1:0]       sel_wr,
    output logic [N_CH-1:0]       status
);
    localparam int N_SEL = N_CH / CH_PER_SEL;
    localparam int N_SNS = N_CH / CH_PER_SNS;

    logic [DATA_W-1:0] sel_q [N_SEL];
    logic [DATA_W-1:0] sns_q [N_SNS];
    logic [N_CH-1:0]   status_q;
    logic [N_CH-1:0]   status_keep;
    logic              status_wr;

    assign status_wr   = wr_en && (wr_addr == ADDR_STATUS);
    assign status_keep = status_wr ? (status_q & wr_data[N_CH-1:0]) : status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_SEL; k++) sel_q[k] <= '0;
            for (int j = 0; j < N_SNS; j++) sns_q[j] <= '0;
            status_q <= '0;
        end else begin
            for (int k = 0; k < N_SEL; k++)
                if (wr_en && wr_addr == sel_addr(k)) sel_q[k] <= wr_data;
            for (int j = 0; j < N_SNS; j++)
                if (wr_en && wr_addr == sns_addr(j)) sns_q[j] <= wr_data;
            status_q <= status_keep | evt_vec;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_STATUS) rd_data[N_CH-1:0] = status_q;
        for (int k = 0; k < N_SEL; k++)
            if (rd_addr == sel_addr(k)) rd_data = sel_q[k];
        for (int j = 0; j < N_SNS; j++)
            if (rd_addr == sns_addr(j)) rd_data = sns_q[j];
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_fields
        assign sel_cfg[c] = src_sel_t'(sel_q[c / CH_PER_SEL][8 * (c % CH_PER_SEL) +: 8]);
        assign sns_cfg[c] = sense_e'(sns_q[c / CH_PER_SNS][2 * (c % CH_PER_SNS) +: 2]);
        assign sel_wr[c]  = wr_en && (wr_addr == sel_addr(c / CH_PER_SEL));
    end

    assign status = status_q;

endmodule

// File: rtl/gim_channel.sv
module gim_channel
    import gim_pkg::*;
#(
    parameter int N_LINES = LINE_COUNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lines,
    input  src_sel_t           sel,
    input  sense_e             sense,
    input  logic               sel_wr,
    output logic               evt
);
    localparam int SRC_SPACE = 2 ** IDX_W;

    logic [SRC_SPACE-1:0] padded;
    logic                 src;
    logic                 prev_q;
    logic                 armed_q;

    always_comb begin
        padded = '0;
        padded[N_LINES-1:0] = lines;
    end

    assign src = padded[sel.idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= src;
            armed_q <= sel.en && !sel_wr;
        end
    end

    always_comb begin
        evt = 1'b0;
        if (sel.en) begin
            unique case (sense)
                SNS_RISE: evt = armed_q &&  src && !prev_q;
                SNS_FALL: evt = armed_q && !src &&  prev_q;
                SNS_HIGH: evt =  src;
                SNS_LOW:  evt = !src;
                default:  evt = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gim_mapper.sv
module gim_mapper
    import gim_pkg::*;
#(
    parameter int N_CH    = CH_COUNT,
    parameter int N_LINES = LINE_COUNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [7:0]         rd_addr,
    output logic [31:0]        rd_data,
    input  logic [N_LINES-1:0] gpio_lines,
    output logic [N_CH-1:0]    irq_req
);
    src_sel_t        sel_cfg [N_CH];
    sense_e          sns_cfg [N_CH];
    logic [N_CH-1:0] sel_wr;
    logic [N_CH-1:0] chan_evt;
    logic [N_CH-1:0] chan_en;
    logic [N_CH-1:0] status;

    gim_regs #(.N_CH(N_CH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .evt_vec (chan_evt),
        .sel_cfg (sel_cfg),
        .sns_cfg (sns_cfg),
        .sel_wr  (sel_wr),
        .status  (status)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        assign chan_en[c] = sel_cfg[c].en;
        gim_channel #(.N_LINES(N_LINES)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .lines  (gpio_lines),
            .sel    (sel_cfg[c]),
            .sense  (sns_cfg[c]),
            .sel_wr (sel_wr[c]),
            .evt    (chan_evt[c])
        );
    end

    assign irq_req = status;

endmodule

// File: rtl/gim_mapper_chk.sv
module gim_mapper_chk #(
    parameter int N_CH = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [7:0]      wr_addr,
    input logic [31:0]     wr_data,
    input logic [N_CH-1:0] en_vec,
    input logic [N_CH-1:0] evt_vec,
    input logic [N_CH-1:0] irq_req
);
    p_disabled_silent_r8: assert property (@(posedge clk) disable iff (rst)
        ((irq_req & ~$past(irq_req) & ~$past(en_vec)) == '0));

    p_set_needs_event_r10: assert property (@(posedge clk) disable iff (rst)
        ((irq_req & ~$past(irq_req) & ~$past(evt_vec)) == '0));

    p_event_wins_r11: assert property (@(posedge clk) disable iff (rst)
        ((irq_req & $past(evt_vec)) == $past(evt_vec)));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(evt_vec) == '0 && !($past(wr_en) && $past(wr_addr) == 8'h20))
        |-> $stable(irq_req));

    p_clear_honoured_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && $past(wr_addr) == 8'h20)
        |-> ((irq_req & ~$past(wr_data[N_CH-1:0]) & ~$past(evt_vec)) == '0));

endmodule

bind gim_mapper gim_mapper_chk #(.N_CH(N_CH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en_vec  (chan_en),
    .evt_vec (chan_evt),
    .irq_req (irq_req)
);

// File: tb/tb_gim_mapper.sv
module tb_gim_mapper;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [7:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [127:0] gpio = '0;
    logic [31:0]  irq_req;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] sel_sh [8];
    logic [31:0] sns_sh [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    gim_mapper dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .gpio_lines (gpio),
        .irq_req    (irq_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic cfg_chan(input int c, input int idx, input bit en, input int sns);
        sns_sh[c / 16][2 * (c % 16) +: 2] = 2'(sns);
        sel_sh[c / 4][8 * (c % 4) +: 8]   = {en, 7'(idx)};
        wr(8'(8'h24 + 4 * (c / 16)), sns_sh[c / 16]);
        wr(8'(8'h30 + 4 * (c / 4)), sel_sh[c / 4]);
        step(2);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(8'(8'h30 + 4 * k), v);
            chk("R1 sel reg", v, 32'h0);
        end
        rd(8'h24, v); chk("R1 sense lo", v, 32'h0);
        rd(8'h28, v); chk("R1 sense hi", v, 32'h0);
        rd(8'h20, v); chk("R1 status", v, 32'h0);
        chk("R1 irq_req", irq_req, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        cfg_chan(13, 77, 1'b1, 0);
        rd(8'h3C, v);
        chk("R2 field at reg 3 byte 1", v, 32'h0000_CD00);
        gpio[77] = 1'b1;
        step();
        chk("R2 routed line 77 to channel 13", irq_req, 32'h1 << 13);
        wr(8'h20, 32'h0);
        cfg_chan(13, 0, 1'b0, 0);
        gpio[77] = 1'b0;
        step();
    endtask

    task automatic t_rise();
        logic [31:0] v;
        cfg_chan(5, 10, 1'b1, 0);
        gpio[10] = 1'b1;
        step();
        chk("R3 rising edge", irq_req, 32'h1 << 5);
        rd(8'h20, v);
        chk("R12 status mirrors irq_req", v, irq_req);
        wr(8'h20, 32'h0);
        step(2);
        chk("R3 held high does not refire", irq_req, 32'h0);
        gpio[10] = 1'b0;
        step();
        chk("R3 falling ignored", irq_req, 32'h0);
    endtask

    task automatic t_write_one();
        gpio[10] = 1'b1;
        step();
        wr(8'h20, 32'hFFFF_FFFF);
        chk("R10 writing ones keeps status", irq_req, 32'h1 << 5);
        wr(8'h20, ~(32'h1 << 5));
        chk("R10 zero bit clears", irq_req, 32'h0);
        gpio[10] = 1'b0;
        cfg_chan(5, 0, 1'b0, 0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        cfg_chan(20, 100, 1'b1, 1);
        rd(8'h28, v);
        chk("R7 channel 20 code in high sense reg", v, 32'h1 << 8);
        gpio[100] = 1'b1;
        step();
        chk("R4 rising ignored", irq_req, 32'h0);
        gpio[100] = 1'b0;
        step();
        chk("R4 falling edge", irq_req, 32'h1 << 20);
        wr(8'h20, 32'h0);
        cfg_chan(20, 0, 1'b0, 0);
    endtask

    task automatic t_level_high();
        cfg_chan(30, 3, 1'b1, 2);
        gpio[3] = 1'b1;
        step();
        chk("R5 level high sets", irq_req, 32'h1 << 30);
        wr(8'h20, 32'h0);
        chk("R11 event wins over clear", irq_req, 32'h1 << 30);
        gpio[3] = 1'b0;
        step();
        wr(8'h20, 32'h0);
        chk("R5 cleared once low", irq_req, 32'h0);
        cfg_chan(30, 0, 1'b0, 0);
    endtask

    task automatic t_level_low();
        logic [31:0] v;
        gpio[127] = 1'b0;
        cfg_chan(16, 127, 1'b1, 3);
        chk("R6 level low sets", irq_req, 32'h1 << 16);
        rd(8'h28, v);
        chk("R7 channel 16 code at bits 1:0", v[1:0], 32'h3);
        rd(8'h24, v);
        chk("R7 low sense reg untouched", v, 32'h0);
        gpio[127] = 1'b1;
        step();
        wr(8'h20, 32'h0);
        chk("R6 high source clears", irq_req, 32'h0);
        cfg_chan(16, 0, 1'b0, 0);
        gpio[127] = 1'b0;
    endtask

    task automatic t_disabled();
        cfg_chan(7, 50, 1'b0, 2);
        gpio[50] = 1'b1;
        step(3);
        chk("R8 disabled level channel silent", irq_req, 32'h0);
        gpio[50] = 1'b0;
        step(2);
        chk("R8 disabled channel ignores toggle", irq_req, 32'h0);
    endtask

    task automatic t_enable_edge();
        cfg_chan(9, 60, 1'b0, 0);
        gpio[60] = 1'b1;
        step();
        cfg_chan(9, 60, 1'b1, 0);
        chk("R9 enable onto high line no edge", irq_req, 32'h0);
        gpio[60] = 1'b0;
        gpio[61] = 1'b1;
        step(2);
        cfg_chan(9, 61, 1'b1, 0);
        chk("R9 index switch onto high line no edge", irq_req, 32'h0);
        gpio[61] = 1'b0;
        step();
        gpio[61] = 1'b1;
        step();
        chk("R9 genuine edge after switch", irq_req, 32'h1 << 9);
        wr(8'h20, 32'h0);
        cfg_chan(9, 0, 1'b0, 0);
        gpio[61] = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < 8; k++) sel_sh[k] = '0;
        for (int j = 0; j < 2; j++) sns_sh[j] = '0;
        step(4);
        rst = 1'b0;
        step();
        t_reset();
        t_layout();
        t_rise();
        t_write_one();
        t_fall();
        t_level_high();
        t_level_low();
        t_disabled();
        t_enable_edge();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule